// File: doc/BRIEF.md
# Access Mask Register File with Masked User Writes

This block holds two 64-bit special-purpose registers that sit beside a page permission checker: the access mask, whose current value is driven out continuously to that checker, and a user-mask register that limits which access mask bits user-state software may change. Software reaches both through a move-to / move-from special-register interface. Each access carries a special-register number, a write flag, write data and a privilege bit.

The access mask answers at two special-register numbers. The user alias (0x00C) may be read and written from either privilege state. When user state writes it, only the bits that the user-mask register allows are stored. The privileged alias (0x01D) and the user-mask register (0x09D) may be reached only from privileged state. A user-state access to either of them raises an illegal-access flag, returns zero on the read port and changes nothing. Both registers reset to zero, so user-state writes to the mask have no effect until privileged software opens the user mask.

The interface is plain control, not a stream. An access is presented for one cycle with `acc_valid` high and is always accepted. Reads are combinational from the registers. A write takes effect at the clock edge that samples `acc_valid` and `acc_write` both high.

Top module: `amr_spr_file`

## Requirements
- R1: After reset, the access mask (`mask_value`) and the user-mask register are both 0.
- R2: A read of SPR 0x00C returns the access mask in both user state (`acc_priv`=0) and privileged state (`acc_priv`=1). `acc_hit` is 1 and `acc_illegal` is 0.
- R3: A user-state write to SPR 0x00C stores `acc_wdata` ANDed with the user-mask register. With the user mask at 0 the mask is unchanged.
- R4: A privileged write to SPR 0x00C stores `acc_wdata` unmasked.
- R5: SPR 0x01D reads and writes the same access mask storage as SPR 0x00C, unmasked, in privileged state.
- R6: SPR 0x09D reads and writes the user-mask register in privileged state.
- R7: A user-state access to SPR 0x01D or 0x09D drives `acc_illegal` to 1 in the same cycle and `acc_rdata` to 0, and leaves both registers unchanged.
- R8: An access to any other SPR number gives `acc_hit`=0, `acc_illegal`=0 and `acc_rdata`=0, and changes no register.
- R9: `mask_value` always shows the stored access mask. A write appears on it one clock edge after it is sampled.
- R10: No register changes unless `acc_valid` and `acc_write` are both 1 at the clock edge. `acc_rdata` is 0 whenever `acc_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access strobe, one access per cycle |
| acc_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| acc_priv | input | 1 | 1 = privileged state, 0 = user state |
| acc_spr | input | 10 | Special-register number |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Read data, combinational, 0 when illegal or unmapped |
| acc_hit | output | 1 | SPR number is one this block decodes |
| acc_illegal | output | 1 | User-state access to a privileged-only number |
| mask_value | output | 64 | Current access mask toward the permission checker |

## Verification
The bench checks that the user-state write through the user alias is masked. A design that stored the raw value would let user software open any key: the mask would change while the user mask is still zero. The same value written from privileged state must land unmasked. A design that masked every write to that alias would then show a cleared field. User-state accesses to the privileged alias and to the user-mask number are tried as both reads and writes. A design that checked privilege only on reads would let such a write change the mask or the user mask. Strobes held low and unmapped numbers must leave both registers untouched.

// File: rtl/amr_spr_pkg.sv
package amr_spr_pkg;
  typedef enum logic [1:0] {
    SEL_NONE      = 2'd0,
    SEL_MASK_USER = 2'd1,
    SEL_MASK_PRIV = 2'd2,
    SEL_UMASK     = 2'd3
  } spr_sel_e;
endpackage

// File: rtl/amr_spr_decode.sv
module amr_spr_decode
  import amr_spr_pkg::*;
#(
  parameter int SPR_W = 10,
  parameter logic [SPR_W-1:0] NUM_MASK_USER = 'h00C,
  parameter logic [SPR_W-1:0] NUM_MASK_PRIV = 'h01D,
  parameter logic [SPR_W-1:0] NUM_UMASK     = 'h09D
) (
  input  logic             valid,
  input  logic             priv,
  input  logic [SPR_W-1:0] spr,
  output spr_sel_e         sel,
  output logic             hit,
  output logic             illegal,
  output logic             allowed
);
  logic priv_only;

  always_comb begin
    sel       = SEL_NONE;
    priv_only = 1'b0;
    if (spr == NUM_MASK_USER) begin
      sel = SEL_MASK_USER;
    end else if (spr == NUM_MASK_PRIV) begin
      sel       = SEL_MASK_PRIV;
      priv_only = 1'b1;
    end else if (spr == NUM_UMASK) begin
      sel       = SEL_UMASK;
      priv_only = 1'b1;
    end
  end

  assign hit     = valid && (sel != SEL_NONE);
  assign illegal = hit && priv_only && !priv;
  assign allowed = hit && !illegal;
endmodule

// File: rtl/amr_spr_wrmask.sv
module amr_spr_wrmask
  import amr_spr_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              allowed,
  input  logic              write,
  input  logic              priv,
  input  spr_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] umask,
  output logic              mask_we,
  output logic [DATA_W-1:0] mask_next,
  output logic              umask_we,
  output logic [DATA_W-1:0] umask_next
);
  logic do_wr;
  logic user_masked;

  assign do_wr       = allowed && write;
  assign user_masked = (sel == SEL_MASK_USER) && !priv;

  assign mask_we  = do_wr && ((sel == SEL_MASK_USER) || (sel == SEL_MASK_PRIV));
  assign umask_we = do_wr && (sel == SEL_UMASK);

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign mask_next[b] = user_masked ? (wdata[b] & umask[b]) : wdata[b];
  end

  assign umask_next = wdata;
endmodule

// File: rtl/amr_spr_regs.sv
module amr_spr_regs #(
  parameter int DATA_W = 64,
  parameter logic [DATA_W-1:0] MASK_RST  = '0,
  parameter logic [DATA_W-1:0] UMASK_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we,
  input  logic [DATA_W-1:0] mask_next,
  input  logic              umask_we,
  input  logic [DATA_W-1:0] umask_next,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] umask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= MASK_RST;
    end else if (mask_we) begin
      mask_q <= mask_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      umask_q <= UMASK_RST;
    end else if (umask_we) begin
      umask_q <= umask_next;
    end
  end
endmodule

// File: rtl/amr_spr_file.sv
module amr_spr_file
  import amr_spr_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SPR_W  = 10,
  parameter logic [SPR_W-1:0] NUM_MASK_USER = 'h00C,
  parameter logic [SPR_W-1:0] NUM_MASK_PRIV = 'h01D,
  parameter logic [SPR_W-1:0] NUM_UMASK     = 'h09D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_priv,
  input  logic [SPR_W-1:0]  acc_spr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              acc_hit,
  output logic              acc_illegal,
  output logic [DATA_W-1:0] mask_value
);
  spr_sel_e          sel;
  logic              allowed;
  logic              mask_we;
  logic              umask_we;
  logic [DATA_W-1:0] mask_next;
  logic [DATA_W-1:0] umask_next;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] umask_q;

  amr_spr_decode #(
    .SPR_W(SPR_W),
    .NUM_MASK_USER(NUM_MASK_USER),
    .NUM_MASK_PRIV(NUM_MASK_PRIV),
    .NUM_UMASK(NUM_UMASK)
  ) u_decode (
    .valid(acc_valid),
    .priv(acc_priv),
    .spr(acc_spr),
    .sel(sel),
    .hit(acc_hit),
    .illegal(acc_illegal),
    .allowed(allowed)
  );

  amr_spr_wrmask #(.DATA_W(DATA_W)) u_wrmask (
    .allowed(allowed),
    .write(acc_write),
    .priv(acc_priv),
    .sel(sel),
    .wdata(acc_wdata),
    .umask(umask_q),
    .mask_we(mask_we),
    .mask_next(mask_next),
    .umask_we(umask_we),
    .umask_next(umask_next)
  );

  amr_spr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk),
    .rst_n(rst_n),
    .mask_we(mask_we),
    .mask_next(mask_next),
    .umask_we(umask_we),
    .umask_next(umask_next),
    .mask_q(mask_q),
    .umask_q(umask_q)
  );

  always_comb begin
    acc_rdata = '0;
    if (allowed) begin
      unique case (sel)
        SEL_MASK_USER, SEL_MASK_PRIV: acc_rdata = mask_q;
        SEL_UMASK:                    acc_rdata = umask_q;
        default:                      acc_rdata = '0;
      endcase
    end
  end

  assign mask_value = mask_q;
endmodule

// File: rtl/amr_spr_file_sva.sv
module amr_spr_file_sva #(
  parameter int DATA_W = 64,
  parameter int SPR_W  = 10,
  parameter logic [SPR_W-1:0] NUM_MASK_USER = 'h00C,
  parameter logic [SPR_W-1:0] NUM_MASK_PRIV = 'h01D,
  parameter logic [SPR_W-1:0] NUM_UMASK     = 'h09D
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_write,
  input logic              acc_priv,
  input logic [SPR_W-1:0]  acc_spr,
  input logic [DATA_W-1:0] acc_wdata,
  input logic [DATA_W-1:0] acc_rdata,
  input logic              acc_illegal,
  input logic [DATA_W-1:0] mask_value,
  input logic [DATA_W-1:0] umask_q
);
  assert_user_write_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && !acc_priv && acc_spr == NUM_MASK_USER)
    |=> mask_value == ($past(acc_wdata) & $past(umask_q)));

  assert_priv_write_unmasked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_priv &&
     (acc_spr == NUM_MASK_USER || acc_spr == NUM_MASK_PRIV))
    |=> mask_value == $past(acc_wdata));

  assert_illegal_only_user_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_illegal |-> (acc_valid && !acc_priv && acc_rdata == '0));

  assert_illegal_no_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_illegal |=> ($stable(mask_value) && $stable(umask_q)));

  assert_no_strobe_no_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_write) |=> ($stable(mask_value) && $stable(umask_q)));

  assert_idle_rdata_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> acc_rdata == '0);
endmodule

bind amr_spr_file amr_spr_file_sva #(
  .DATA_W(DATA_W),
  .SPR_W(SPR_W),
  .NUM_MASK_USER(NUM_MASK_USER),
  .NUM_MASK_PRIV(NUM_MASK_PRIV),
  .NUM_UMASK(NUM_UMASK)
) u_sva (
  .clk(clk),
  .rst_n(rst_n),
  .acc_valid(acc_valid),
  .acc_write(acc_write),
  .acc_priv(acc_priv),
  .acc_spr(acc_spr),
  .acc_wdata(acc_wdata),
  .acc_rdata(acc_rdata),
  .acc_illegal(acc_illegal),
  .mask_value(mask_value),
  .umask_q(umask_q)
);

// File: tb/amr_spr_file_bench.sv
module amr_spr_file_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic        acc_priv = 1'b0;
  logic [9:0]  acc_spr = '0;
  logic [63:0] acc_wdata = '0;
  logic [63:0] acc_rdata;
  logic        acc_hit;
  logic        acc_illegal;
  logic [63:0] mask_value;

  int n_vec = 0;
  int n_bad = 0;

  localparam logic [9:0] S_USER  = 10'h00C;
  localparam logic [9:0] S_PRIV  = 10'h01D;
  localparam logic [9:0] S_UMASK = 10'h09D;

  always #4 clk = ~clk;

  amr_spr_file u_amr_spr_file (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_priv(acc_priv), .acc_spr(acc_spr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .acc_hit(acc_hit), .acc_illegal(acc_illegal),
    .mask_value(mask_value)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    acc_valid = 1'b0; acc_write = 1'b0; acc_priv = 1'b0;
    acc_spr = '0; acc_wdata = '0;
  endtask

  // drive at negedge, write lands at next posedge, return at following negedge
  task automatic do_write(input logic priv, input logic [9:0] spr, input logic [63:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_priv = priv; acc_spr = spr; acc_wdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic do_read(input logic priv, input logic [9:0] spr, output logic [63:0] d,
                         output logic hit, output logic ill);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_priv = priv; acc_spr = spr; acc_wdata = '0;
    #1;
    d = acc_rdata; hit = acc_hit; ill = acc_illegal;
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    logic [63:0] d; logic h, i;
    check("R1 mask after reset", mask_value, 64'd0);
    do_read(1'b1, S_UMASK, d, h, i);
    check("R1 user mask after reset", d, 64'd0);
    do_read(1'b0, S_USER, d, h, i);
    check("R2 user read of alias", d, 64'd0);
    check("R2 hit on user alias", {63'd0, h}, 64'd1);
    check("R2 no illegal on user alias", {63'd0, i}, 64'd0);
  endtask

  task automatic t_masked_write();
    logic [63:0] d; logic h, i;
    do_write(1'b0, S_USER, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R3 user write with closed user mask", mask_value, 64'd0);
    do_write(1'b1, S_UMASK, 64'h00FF_00FF_F0F0_1234);
    do_read(1'b1, S_UMASK, d, h, i);
    check("R6 user mask read back", d, 64'h00FF_00FF_F0F0_1234);
    do_write(1'b0, S_USER, 64'hFFFF_0000_FFFF_FFFF);
    check("R3 R9 masked user write", mask_value, 64'h00FF_0000_F0F0_1234);
    do_read(1'b1, S_USER, d, h, i);
    check("R2 privileged read of user alias", d, 64'h00FF_0000_F0F0_1234);
  endtask

  task automatic t_priv_write();
    logic [63:0] d; logic h, i;
    do_write(1'b1, S_USER, 64'hDEAD_BEEF_0123_4567);
    check("R4 unmasked privileged write", mask_value, 64'hDEAD_BEEF_0123_4567);
    do_write(1'b1, S_PRIV, 64'hA5A5_5A5A_C3C3_3C3C);
    check("R5 privileged alias write", mask_value, 64'hA5A5_5A5A_C3C3_3C3C);
    do_read(1'b0, S_USER, d, h, i);
    check("R5 shared storage via user alias", d, 64'hA5A5_5A5A_C3C3_3C3C);
    do_read(1'b1, S_PRIV, d, h, i);
    check("R5 privileged alias read", d, 64'hA5A5_5A5A_C3C3_3C3C);
  endtask

  task automatic t_illegal();
    logic [63:0] d; logic h, i;
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_priv = 1'b0; acc_spr = S_PRIV;
    acc_wdata = 64'h1111_2222_3333_4444;
    #1;
    check("R7 illegal flag on user write of priv alias", {63'd0, acc_illegal}, 64'd1);
    check("R7 rdata zero on illegal", acc_rdata, 64'd0);
    @(negedge clk);
    idle();
    check("R7 mask unchanged after illegal write", mask_value, 64'hA5A5_5A5A_C3C3_3C3C);
    do_write(1'b0, S_UMASK, 64'hFFFF_FFFF_FFFF_FFFF);
    do_read(1'b1, S_UMASK, d, h, i);
    check("R7 user mask unchanged after illegal write", d, 64'h00FF_00FF_F0F0_1234);
    do_read(1'b0, S_UMASK, d, h, i);
    check("R7 illegal user read of user mask", {63'd0, i}, 64'd1);
    check("R7 illegal read returns zero", d, 64'd0);
  endtask

  task automatic t_unmapped();
    logic [63:0] d; logic h, i;
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_priv = 1'b1; acc_spr = 10'h123;
    acc_wdata = 64'h0;
    #1;
    check("R8 no hit on unmapped", {63'd0, acc_hit}, 64'd0);
    check("R8 no illegal on unmapped", {63'd0, acc_illegal}, 64'd0);
    check("R8 rdata zero on unmapped", acc_rdata, 64'd0);
    @(negedge clk);
    idle();
    check("R8 mask unchanged by unmapped write", mask_value, 64'hA5A5_5A5A_C3C3_3C3C);
    do_read(1'b1, S_UMASK, d, h, i);
    check("R8 user mask unchanged by unmapped write", d, 64'h00FF_00FF_F0F0_1234);
  endtask

  task automatic t_strobes();
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b1; acc_priv = 1'b1; acc_spr = S_USER;
    acc_wdata = 64'h0;
    #1;
    check("R10 rdata zero with valid low", acc_rdata, 64'd0);
    @(negedge clk);
    check("R10 no write with valid low", mask_value, 64'hA5A5_5A5A_C3C3_3C3C);
    acc_valid = 1'b1; acc_write = 1'b0;
    @(negedge clk);
    idle();
    check("R10 no write on read access", mask_value, 64'hA5A5_5A5A_C3C3_3C3C);
  endtask

  initial begin
    #(8 * 5000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_masked_write();
    t_priv_write();
    t_illegal();
    t_unmapped();
    t_strobes();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule